// File: doc/BRIEF.md
# Pooled Mini-Filter Prefix Membership Engine

This block answers, for one destination address, which prefix lengths may hold a stored prefix that covers it. It does this with a pool of equal-size mini Bloom filters instead of one large filter per length. A run-time allocation table gives each prefix length a run of mini filters, described by a base index and a count. A primary hash of the masked prefix picks exactly one mini filter inside that run. Programming a prefix sets bits only in that mini filter, and a query probes only that mini filter for each length.

Every mini filter is split into equal segments, so that each segment needs to serve no more hash functions than a memory has read ports. Each secondary hash function addresses only its own segment. A lookup address goes to all lengths at once and returns one match bit per length two cycles later. A downstream engine can then probe exact-match tables from the longest flagged length down. Allocation changes are staged and take effect only when no lookup is being accepted or is in flight.

Top module: `lpm_bloom_pool`

## Requirements
- R1: After reset every length has a count of zero, every mini filter is empty and `match_valid` is low, so any lookup returns an all-zero `match_vec`.
- R2: A `tbl_we` pulse stores (`tbl_base`, `tbl_count`) for length index `tbl_len` in a staged copy. The staged copy becomes active on the first clock edge at which `lookup_valid` is low and no lookup is in flight. The active table never changes while a lookup is accepted or in flight, so lookups issued before that edge use the old allocation.
- R3: For length index l (prefix length P = l+1), the hash word is X = (P << ADDR_W) | K, where K is the address with its ADDR_W-P low bits cleared. The selected mini filter is (base + ((X*0x9E3779B1 mod 2^32) >> 24) mod count) mod NUM_MINI.
- R4: Secondary hash j (0..NUM_HASH-1) uses the multiplier 0x85EBCA6B + j*0x27D4EB2E. Its index inside a segment is the top log2(SEG_BITS) bits of X times that multiplier (mod 2^32), and it lies in segment j / RD_PORTS. Its bit position in the mini filter is segment*SEG_BITS + index, with SEG_BITS = MINI_BITS*RD_PORTS/NUM_HASH. With the defaults, hashes 0 and 1 use bits 0..31 and hashes 2 and 3 use bits 32..63. One programming operation sets at most NUM_HASH bits, all in the selected mini filter.
- R5: Programming a length whose active count is zero changes no filter bit.
- R6: `match_vec` bit l is 1 exactly when the active count for length index l is non-zero and all NUM_HASH bits from R4 are set in the mini filter chosen by R3 for the lookup address. A length with count zero always reports 0.
- R7: `match_valid` is high exactly two cycles after `lookup_valid` is accepted. Back-to-back lookups give back-to-back results, and `match_vec` is zero whenever `match_valid` is low.
- R8: A lookup of any address covered by a prefix programmed under the current allocation of its length reports 1 for that length (no false negatives).
- R9: Filter bits are only ever set. Later programming never clears a bit that an earlier prefix set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Write one staged allocation entry |
| tbl_len | input | LEN_W | Length index of the entry (prefix length minus one) |
| tbl_base | input | MINI_W | First mini filter of the length's run |
| tbl_count | input | CNT_W | Number of mini filters in the run (0 disables the length) |
| prog_valid | input | 1 | Insert one prefix |
| prog_len | input | LEN_W | Length index of the inserted prefix |
| prog_addr | input | ADDR_W | Prefix bits; bits below the length are ignored |
| lookup_valid | input | 1 | Start a lookup |
| lookup_addr | input | ADDR_W | Address to look up |
| match_valid | output | 1 | Result of a lookup is present |
| match_vec | output | NUM_LEN | Bit l set: length l+1 may hold a covering prefix |

## Verification
The checker watches on every cycle the two-cycle result timing and the zero result vector when idle. It also checks that a length with no mini filters never flags, that the active allocation holds still while lookups are in flight, that filter bits never clear, that a programming pulse for an empty length leaves the filters alone, and that one insert sets no more bits than there are hash functions. Whether the right mini filter and the right segment bits are chosen can only be shown by the bench: its scenarios compare every result vector against a model built from the hash definitions. They also show that reallocation during a lookup stream is deferred and that every programmed prefix is still found after further inserts.

// File: rtl/lpm_pool_pkg.sv
package lpm_pool_pkg;

    localparam logic [31:0] PRIM_MULT     = 32'h9E37_79B1;
    localparam logic [31:0] SEC_MULT_BASE = 32'h85EB_CA6B;
    localparam logic [31:0] SEC_MULT_STEP = 32'h27D4_EB2E;

    // Hash word: prefix length above the masked key.
    function automatic logic [31:0] fold_key(input logic [31:0] plen,
                                             input logic [31:0] key,
                                             input int unsigned aw);
        return (plen << aw) | key;
    endfunction

    // Top byte of the primary product.
    function automatic logic [7:0] prim_tag(input logic [31:0] word);
        return 8'((word * PRIM_MULT) >> 24);
    endfunction

    // Top `width` bits of the product for secondary hash j, right aligned.
    function automatic logic [31:0] sec_top(input logic [31:0] word,
                                            input int unsigned j,
                                            input int unsigned width);
        logic [31:0] mult;
        mult = SEC_MULT_BASE + (32'(j) * SEC_MULT_STEP);
        return (word * mult) >> (32 - width);
    endfunction

endpackage

// File: rtl/lpm_alloc_table.sv
module lpm_alloc_table #(
    parameter  int NUM_LEN  = 16,
    parameter  int NUM_MINI = 16,
    localparam int LEN_W    = $clog2(NUM_LEN),
    localparam int MINI_W   = $clog2(NUM_MINI),
    localparam int CNT_W    = $clog2(NUM_MINI + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [LEN_W-1:0]                  wr_len,
    input  logic [MINI_W-1:0]                 wr_base,
    input  logic [CNT_W-1:0]                  wr_count,
    input  logic                              hold,
    output logic [NUM_LEN-1:0][MINI_W-1:0]    act_base,
    output logic [NUM_LEN-1:0][CNT_W-1:0]     act_count
);

    typedef struct packed {
        logic                           pend;
        logic [NUM_LEN-1:0][MINI_W-1:0] stg_base;
        logic [NUM_LEN-1:0][CNT_W-1:0]  stg_count;
        logic [NUM_LEN-1:0][MINI_W-1:0] cur_base;
        logic [NUM_LEN-1:0][CNT_W-1:0]  cur_count;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        // Swap in the staged copy only between lookups.
        if (tbl_q.pend && !hold) begin
            tbl_d.cur_base  = tbl_q.stg_base;
            tbl_d.cur_count = tbl_q.stg_count;
            tbl_d.pend      = 1'b0;
        end
        if (wr_en) begin
            tbl_d.stg_base[wr_len]  = wr_base;
            tbl_d.stg_count[wr_len] = wr_count;
            tbl_d.pend              = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign act_base  = tbl_q.cur_base;
    assign act_count = tbl_q.cur_count;

endmodule

// File: rtl/lpm_mini_select.sv
module lpm_mini_select #(
    parameter  int ADDR_W   = 16,
    parameter  int NUM_LEN  = 16,
    parameter  int NUM_MINI = 16,
    localparam int MINI_W   = $clog2(NUM_MINI),
    localparam int CNT_W    = $clog2(NUM_MINI + 1)
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [NUM_LEN-1:0][MINI_W-1:0]    base,
    input  logic [NUM_LEN-1:0][CNT_W-1:0]     count,
    output logic [NUM_LEN-1:0][MINI_W-1:0]    sel,
    output logic [NUM_LEN-1:0]                live
);

    for (genvar l = 0; l < NUM_LEN; l++) begin : g_len
        localparam logic [ADDR_W-1:0] KMASK = {ADDR_W{1'b1}} << (ADDR_W - l - 1);
        logic [7:0]  tag;
        logic [7:0]  off;
        logic [31:0] sum;

        always_comb begin
            tag = lpm_pool_pkg::prim_tag(
                      lpm_pool_pkg::fold_key(32'(l + 1), 32'(addr & KMASK), ADDR_W));
            off = (count[l] == '0) ? 8'd0 : 8'(32'(tag) % 32'(count[l]));
            sum = 32'(base[l]) + 32'(off);
            sel[l]  = MINI_W'(sum % 32'(NUM_MINI));
            live[l] = (count[l] != '0);
        end
    end

endmodule

// File: rtl/lpm_mini_pool.sv
module lpm_mini_pool #(
    parameter  int ADDR_W    = 16,
    parameter  int NUM_LEN   = 16,
    parameter  int NUM_MINI  = 16,
    parameter  int MINI_BITS = 64,
    parameter  int NUM_HASH  = 4,
    parameter  int RD_PORTS  = 2,
    localparam int MINI_W    = $clog2(NUM_MINI),
    localparam int LEN_W     = $clog2(NUM_LEN)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [LEN_W-1:0]                   wr_len,
    input  logic [MINI_W-1:0]                  wr_mini,
    input  logic [ADDR_W-1:0]                  wr_addr,
    input  logic                               rd_en,
    input  logic [ADDR_W-1:0]                  rd_addr,
    input  logic [NUM_LEN-1:0][MINI_W-1:0]     rd_sel,
    input  logic [NUM_LEN-1:0]                 rd_live,
    output logic                               hit_valid,
    output logic [NUM_LEN-1:0]                 hit_vec,
    output logic [NUM_MINI-1:0][MINI_BITS-1:0] fill_o
);

    localparam int NSEG     = NUM_HASH / RD_PORTS;
    localparam int SEG_BITS = MINI_BITS / NSEG;
    localparam int SEG_IW   = $clog2(SEG_BITS);
    localparam int BIT_W    = $clog2(MINI_BITS);

    typedef struct packed {
        logic                               valid;
        logic [NUM_LEN-1:0]                 hits;
        logic [NUM_MINI-1:0][MINI_BITS-1:0] fill;
    } pool_t;

    pool_t pool_d, pool_q;

    // Hash j may only land in segment j / RD_PORTS.
    function automatic logic [BIT_W-1:0] slot_of(input logic [31:0] word,
                                                 input int unsigned j);
        logic [31:0] idx;
        idx = lpm_pool_pkg::sec_top(word, j, SEG_IW);
        return BIT_W'((j / RD_PORTS) * SEG_BITS) + BIT_W'(idx);
    endfunction

    function automatic logic [31:0] word_of(input int unsigned plen,
                                            input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] mask;
        mask = {ADDR_W{1'b1}} << (ADDR_W - plen);
        return lpm_pool_pkg::fold_key(32'(plen), 32'(a & mask), ADDR_W);
    endfunction

    always_comb begin
        logic [31:0]          word;
        logic [MINI_BITS-1:0] row;
        logic                 all_set;
        pool_d       = pool_q;
        pool_d.valid = rd_en;
        pool_d.hits  = '0;
        for (int l = 0; l < NUM_LEN; l++) begin
            word    = word_of(l + 1, rd_addr);
            row     = pool_q.fill[rd_sel[l]];
            all_set = 1'b1;
            for (int j = 0; j < NUM_HASH; j++) begin
                if (!row[slot_of(word, j)]) all_set = 1'b0;
            end
            pool_d.hits[l] = rd_en && rd_live[l] && all_set;
        end
        if (wr_en) begin
            word = word_of(32'(wr_len) + 1, wr_addr);
            for (int j = 0; j < NUM_HASH; j++) begin
                pool_d.fill[wr_mini][slot_of(word, j)] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pool_q <= '0;
        else        pool_q <= pool_d;
    end

    assign hit_valid = pool_q.valid;
    assign hit_vec   = pool_q.hits;
    assign fill_o    = pool_q.fill;

endmodule

// File: rtl/lpm_bloom_pool.sv
module lpm_bloom_pool #(
    parameter  int ADDR_W    = 16,
    parameter  int NUM_LEN   = 16,
    parameter  int NUM_MINI  = 16,
    parameter  int MINI_BITS = 64,
    parameter  int NUM_HASH  = 4,
    parameter  int RD_PORTS  = 2,
    localparam int LEN_W     = $clog2(NUM_LEN),
    localparam int MINI_W    = $clog2(NUM_MINI),
    localparam int CNT_W     = $clog2(NUM_MINI + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [LEN_W-1:0]   tbl_len,
    input  logic [MINI_W-1:0]  tbl_base,
    input  logic [CNT_W-1:0]   tbl_count,
    input  logic               prog_valid,
    input  logic [LEN_W-1:0]   prog_len,
    input  logic [ADDR_W-1:0]  prog_addr,
    input  logic               lookup_valid,
    input  logic [ADDR_W-1:0]  lookup_addr,
    output logic               match_valid,
    output logic [NUM_LEN-1:0] match_vec
);

    typedef struct packed {
        logic                           valid;
        logic [ADDR_W-1:0]              addr;
        logic [NUM_LEN-1:0][MINI_W-1:0] sel;
        logic [NUM_LEN-1:0]             live;
    } stage_t;

    stage_t s1_d, s1_q;

    logic [NUM_LEN-1:0][MINI_W-1:0]     act_base;
    logic [NUM_LEN-1:0][CNT_W-1:0]      act_count;
    logic [NUM_LEN-1:0][MINI_W-1:0]     q_sel;
    logic [NUM_LEN-1:0]                 q_live;
    logic [NUM_LEN-1:0][MINI_W-1:0]     p_sel;
    logic [NUM_LEN-1:0]                 p_live;
    logic                               prog_live;
    logic [NUM_MINI-1:0][MINI_BITS-1:0] fill;

    lpm_alloc_table #(.NUM_LEN(NUM_LEN), .NUM_MINI(NUM_MINI)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_we),
        .wr_len    (tbl_len),
        .wr_base   (tbl_base),
        .wr_count  (tbl_count),
        .hold      (lookup_valid || s1_q.valid),
        .act_base  (act_base),
        .act_count (act_count)
    );

    lpm_mini_select #(.ADDR_W(ADDR_W), .NUM_LEN(NUM_LEN), .NUM_MINI(NUM_MINI)) u_qsel (
        .addr  (lookup_addr),
        .base  (act_base),
        .count (act_count),
        .sel   (q_sel),
        .live  (q_live)
    );

    lpm_mini_select #(.ADDR_W(ADDR_W), .NUM_LEN(NUM_LEN), .NUM_MINI(NUM_MINI)) u_psel (
        .addr  (prog_addr),
        .base  (act_base),
        .count (act_count),
        .sel   (p_sel),
        .live  (p_live)
    );

    assign prog_live = p_live[prog_len];

    always_comb begin
        s1_d       = s1_q;
        s1_d.valid = lookup_valid;
        if (lookup_valid) begin
            s1_d.addr = lookup_addr;
            s1_d.sel  = q_sel;
            s1_d.live = q_live;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    lpm_mini_pool #(
        .ADDR_W(ADDR_W), .NUM_LEN(NUM_LEN), .NUM_MINI(NUM_MINI),
        .MINI_BITS(MINI_BITS), .NUM_HASH(NUM_HASH), .RD_PORTS(RD_PORTS)
    ) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prog_valid && prog_live),
        .wr_len    (prog_len),
        .wr_mini   (p_sel[prog_len]),
        .wr_addr   (prog_addr),
        .rd_en     (s1_q.valid),
        .rd_addr   (s1_q.addr),
        .rd_sel    (s1_q.sel),
        .rd_live   (s1_q.live),
        .hit_valid (match_valid),
        .hit_vec   (match_vec),
        .fill_o    (fill)
    );

endmodule

// File: rtl/lpm_bloom_pool_chk.sv
module lpm_bloom_pool_chk #(
    parameter int NUM_LEN   = 16,
    parameter int NUM_MINI  = 16,
    parameter int MINI_BITS = 64,
    parameter int NUM_HASH  = 4,
    parameter int CNT_W     = 5
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               lookup_valid,
    input logic                               s1_valid,
    input logic [NUM_LEN-1:0]                 s1_live,
    input logic                               match_valid,
    input logic [NUM_LEN-1:0]                 match_vec,
    input logic [NUM_LEN-1:0][CNT_W-1:0]      act_count,
    input logic                               prog_valid,
    input logic                               prog_live,
    input logic [NUM_MINI-1:0][MINI_BITS-1:0] fill
);

    AST_RESULT_TWO_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |-> ##2 match_valid); // R7

    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !match_valid |-> (match_vec == '0)); // R7

    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid || s1_valid) |=> $stable(act_count)); // R2

    AST_FILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fill & $past(fill)) == $past(fill))); // R9

    AST_EMPTY_PROG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_valid && !prog_live) |=> $stable(fill)); // R5

    AST_PROG_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(fill) <= $past($countones(fill)) + NUM_HASH)); // R4

    for (genvar l = 0; l < NUM_LEN; l++) begin : g_empty
        AST_EMPTY_SET_MISS: assert property (@(posedge clk) disable iff (!rst_n)
            (s1_valid && !s1_live[l]) |=> !match_vec[l]); // R6
    end

endmodule

bind lpm_bloom_pool lpm_bloom_pool_chk #(
    .NUM_LEN(NUM_LEN), .NUM_MINI(NUM_MINI), .MINI_BITS(MINI_BITS),
    .NUM_HASH(NUM_HASH), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_valid (lookup_valid),
    .s1_valid     (s1_q.valid),
    .s1_live      (s1_q.live),
    .match_valid  (match_valid),
    .match_vec    (match_vec),
    .act_count    (act_count),
    .prog_valid   (prog_valid),
    .prog_live    (prog_live),
    .fill         (fill)
);

// File: tb/lpm_bloom_pool_test.sv
module lpm_bloom_pool_test;

    localparam int ADDR_W = 16;
    localparam int NLEN   = 16;
    localparam int NMINI  = 16;
    localparam int MBITS  = 64;
    localparam int NHASH  = 4;
    localparam int PORTS  = 2;
    localparam int SEGB   = MBITS / (NHASH / PORTS);
    localparam int SEGIW  = $clog2(SEGB);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_len = '0;
    logic [3:0]  tbl_base = '0;
    logic [4:0]  tbl_count = '0;
    logic        prog_valid = 1'b0;
    logic [3:0]  prog_len = '0;
    logic [15:0] prog_addr = '0;
    logic        lookup_valid = 1'b0;
    logic [15:0] lookup_addr = '0;
    logic        match_valid;
    logic [15:0] match_vec;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [MBITS-1:0] m_fill [NMINI];
    int               m_base [NLEN];
    int               m_cnt  [NLEN];
    logic [15:0]      stored_addr [64];
    int               stored_len  [64];
    int               n_stored = 0;

    always #4 clk = ~clk;

    lpm_bloom_pool uut (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_len(tbl_len), .tbl_base(tbl_base), .tbl_count(tbl_count),
        .prog_valid(prog_valid), .prog_len(prog_len), .prog_addr(prog_addr),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .match_valid(match_valid), .match_vec(match_vec)
    );

    // Model of the hash definitions in the requirements.
    function automatic logic [31:0] m_word(input int l, input logic [15:0] a);
        int plen = l + 1;
        logic [15:0] k = a & (16'hFFFF << (16 - plen));
        return (32'(plen) << ADDR_W) | 32'(k);
    endfunction

    function automatic int m_sel(input int l, input logic [15:0] a);
        logic [31:0] p = m_word(l, a) * 32'h9E3779B1;
        return (m_base[l] + (int'(p[31:24]) % m_cnt[l])) % NMINI;
    endfunction

    function automatic int m_slot(input int l, input logic [15:0] a, input int j);
        logic [31:0] mul = 32'h85EBCA6B + 32'(j) * 32'h27D4EB2E;
        logic [31:0] p = m_word(l, a) * mul;
        return (j / PORTS) * SEGB + int'(p >> (32 - SEGIW));
    endfunction

    function automatic logic [15:0] m_expect(input logic [15:0] a);
        logic [15:0] v = '0;
        for (int l = 0; l < NLEN; l++) begin
            if (m_cnt[l] != 0) begin
                int mi = m_sel(l, a);
                bit ok = 1'b1;
                for (int j = 0; j < NHASH; j++)
                    if (!m_fill[mi][m_slot(l, a, j)]) ok = 1'b0;
                v[l] = ok;
            end
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_tbl(input int l, input int b, input int c);
        @(negedge clk);
        tbl_we = 1'b1; tbl_len = 4'(l); tbl_base = 4'(b); tbl_count = 5'(c);
        @(negedge clk);
        tbl_we = 1'b0;
        @(negedge clk);
        m_base[l] = b; m_cnt[l] = c;
    endtask

    task automatic prog(input int l, input logic [15:0] a);
        @(negedge clk);
        prog_valid = 1'b1; prog_len = 4'(l); prog_addr = a;
        if (m_cnt[l] != 0) begin
            int mi = m_sel(l, a);
            for (int j = 0; j < NHASH; j++) m_fill[mi][m_slot(l, a, j)] = 1'b1;
            if (n_stored < 64) begin
                stored_addr[n_stored] = a; stored_len[n_stored] = l; n_stored++;
            end
        end
        @(negedge clk);
        prog_valid = 1'b0;
    endtask

    task automatic look(input logic [15:0] a, input string req);
        logic [15:0] e;
        @(negedge clk);
        lookup_valid = 1'b1; lookup_addr = a;
        e = m_expect(a);
        @(negedge clk);
        lookup_valid = 1'b0;
        @(negedge clk);
        check(match_valid === 1'b1, {req, " valid"}, 32'(match_valid), 32'd1);
        check(match_vec === e, req, 32'(match_vec), 32'(e));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NMINI; i++) m_fill[i] = '0;
        for (int l = 0; l < NLEN; l++) begin m_base[l] = 0; m_cnt[l] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(match_valid === 1'b0, "R1 reset valid", 32'(match_valid), 32'd0);
        check(match_vec === 16'h0, "R1 reset vec", 32'(match_vec), 32'd0);
        look(16'hA5C3, "R1 lookup after reset");

        // R2: reallocation deferred while lookups stream
        set_tbl(3, 0, 1);
        prog(3, 16'hB000);
        @(negedge clk);
        lookup_valid = 1'b1; lookup_addr = 16'hB123;
        tbl_we = 1'b1; tbl_len = 4'd3; tbl_base = 4'd1; tbl_count = 5'd1;
        @(negedge clk);
        tbl_we = 1'b0; lookup_addr = 16'hB456;
        @(negedge clk);
        lookup_valid = 1'b0;
        check(match_valid === 1'b1, "R7 first result timing", 32'(match_valid), 32'd1);
        check(match_vec[3] === 1'b1, "R2 first lookup old table", 32'(match_vec), 32'h8);
        @(negedge clk);
        check(match_valid === 1'b1, "R7 back-to-back result", 32'(match_valid), 32'd1);
        check(match_vec[3] === 1'b1, "R2 in-flight lookup old table", 32'(match_vec), 32'h8);
        @(negedge clk);
        check(match_valid === 1'b0, "R7 valid drops", 32'(match_valid), 32'd0);
        check(match_vec === 16'h0, "R7 idle vec zero", 32'(match_vec), 32'd0);
        m_base[3] = 1; m_cnt[3] = 1;
        look(16'hB789, "R2 new table after idle");

        // R5: programming an empty length is ignored
        prog(5, 16'h4C00);
        set_tbl(5, 6, 2);
        look(16'h4C00, "R5 empty-length program ignored");

        // R4 / R8: directed prefix at the full length and at length 1
        set_tbl(15, 9, 3);
        prog(15, 16'h1234);
        look(16'h1234, "R4 full-length prefix bits");
        check(match_vec[15] === 1'b1, "R8 full length hit", 32'(match_vec), 32'h8000);
        set_tbl(0, 12, 4);
        prog(0, 16'h8000);
        look(16'hFFFF, "R3 length-one selection");
        check(match_vec[0] === 1'b1, "R8 length-one hit", 32'(match_vec), 32'h1);

        // R6: zero-count length reports nothing even with bits set
        set_tbl(15, 9, 0);
        look(16'h1234, "R6 zero count no match");
        check(match_vec[15] === 1'b0, "R6 zero count bit", 32'(match_vec), 32'h0);

        // R3 / R6: random allocation, random prefixes, random lookups
        for (int l = 0; l < NLEN; l++)
            set_tbl(l, int'($urandom % NMINI), int'($urandom % 5));
        for (int i = 0; i < 40; i++) begin
            int l = int'($urandom % NLEN);
            prog(l, 16'($urandom));
        end
        for (int i = 0; i < 150; i++) begin
            a = 16'($urandom);
            look(a, "R6 random lookup");
        end
        for (int i = 0; i < n_stored; i++) begin
            int l = stored_len[i];
            if (m_base[l] == m_base[l] && m_cnt[l] != 0) begin
                a = stored_addr[i] | (16'hFFFF >> (l + 1));
                look(a, "R3 programmed lookup");
            end
        end

        // R9 / R8: all prefixes programmed under the current table still hit
        for (int i = 0; i < 20; i++) begin
            int l = int'($urandom % NLEN);
            if (m_cnt[l] == 0) set_tbl(l, int'($urandom % NMINI), 2);
            a = 16'($urandom);
            prog(l, a);
            look(a, "R9 new prefix");
            check(match_vec[l] === 1'b1, "R8 no false negative", 32'(match_vec),
                  32'(16'h1 << l));
        end
        for (int i = 0; i < n_stored; i++) begin
            int l = stored_len[i];
            look(stored_addr[i], "R9 earlier prefix kept");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule